// File: doc/BRIEF.md
# Ordered Tagged Memory Request Port

This block sits between a processor core and a small word-addressed memory. The core pushes tagged requests into a request queue. Each request is either a load from an address or a store of a value to an address. Each cycle, the memory side takes the request at the head of that queue and serves it. A served load pushes a reply into a reply queue that carries the same tag and the word currently stored at the address. A served store writes the memory and then pushes a reply that carries the same tag and an acknowledgment marker. Requests never overtake one another, so the memory sees the core's accesses in the order the core issued them.

On the core side, a small issue gate decides whether a request is admitted. A store is held back while the core reports that an older conditional branch is still unresolved. Loads are not held back by that condition. The core retires work by taking replies from the reply queue, which uses a valid/ready handshake, and matching them to its own entries by tag.

Top module: `ordered_mem_port`

## Requirements
- R1: After reset the reply output is not valid, `reqReady` is 1 while `branchOpen` is 0, and every memory word reads as zero.
- R2: Replies leave the reply queue in exactly the order in which their requests were admitted, even while both queues hold several entries.
- R3: A load reply carries the request's tag, `rspIsAck` = 0, and in `rspData` the memory word at the load address, as left by all earlier admitted stores.
- R4: A store writes its data to its address, and its reply carries the request's tag, `rspIsAck` = 1 and `rspData` = 0.
- R5: While `branchOpen` is 1, a store request sees `reqReady` = 0 and is not admitted: it produces no reply and leaves memory unchanged. A load request in the same situation is still admitted.
- R6: The request queue holds 4 entries. With the reply queue also full (4 replies), `reqReady` is 0, so at most 8 admitted requests are outstanding.
- R7: While the reply queue is full, the memory side serves nothing. Requests that are already queued wait without loss and are served in order once replies are taken.
- R8: A valid reply stays valid, with tag, marker and data unchanged, until it is taken with `rspReady` = 1. At most one reply is taken per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Core offers a request |
| reqReady | output | 1 | Request admitted on this edge if valid |
| reqTag | input | 3 | Tag chosen by the core |
| reqIsStore | input | 1 | 1 = store, 0 = load |
| reqAddr | input | 8 | Word address |
| reqData | input | 16 | Store data |
| branchOpen | input | 1 | An older conditional branch is unresolved |
| rspValid | output | 1 | Reply available |
| rspReady | input | 1 | Core takes the reply |
| rspTag | output | 3 | Tag of the reply |
| rspIsAck | output | 1 | 1 = store acknowledgment, 0 = load data |
| rspData | output | 16 | Load data, zero for acknowledgments |

## Verification
The hardest state to reach is the one in which both queues are full at once. In that state the memory side stalls with requests still waiting. To reach it, the bench holds `rspReady` low and pushes eight mixed loads and stores, including a store followed by a load of the same address. It then checks that a ninth request is refused. Next it drains the replies one at a time, so each freed slot lets the stalled queue advance. Every reply is compared in turn against an in-order reference model. A second directed case holds `branchOpen` high with a store offered. It confirms that the store is refused, that a load still passes, and that a later load of the store's address still sees the old value.

// File: rtl/omp_pkg.sv
package omp_pkg;
  localparam int TAG_W  = 3;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic              isStore;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } req_t;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic              isAck;
    logic [DATA_W-1:0] data;
  } rsp_t;

  typedef struct packed {
    logic acceptReq;
    logic serve;
    logic writeMem;
  } strobes_t;
endpackage

// File: rtl/omp_fifo.sv
module omp_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] slots [DEPTH];
  logic [PW-1:0]    wrPtr, rdPtr;
  logic [CW-1:0]    count;
  logic             doPush, doPop;

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign dout   = slots[rdPtr];

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) slots[wrPtr] <= din;
  end
endmodule

// File: rtl/omp_control.sv
module omp_control
  import omp_pkg::*;
(
  input  logic     reqValid,
  input  logic     reqIsStore,
  input  logic     branchOpen,
  input  logic     reqFull,
  input  logic     reqEmpty,
  input  logic     rspFull,
  input  logic     headIsStore,
  output logic     reqReady,
  output strobes_t strobes
);
  logic storeBlocked;

  always_comb begin
    storeBlocked      = reqIsStore && branchOpen;
    reqReady          = !reqFull && !storeBlocked;
    strobes.acceptReq = reqValid && reqReady;
    strobes.serve     = !reqEmpty && !rspFull;
    strobes.writeMem  = strobes.serve && headIsStore;
  end
endmodule

// File: rtl/omp_datapath.sv
module omp_datapath
  import omp_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  strobes_t strobes,
  input  req_t     reqIn,
  input  logic     rspPop,
  output rsp_t     rspOut,
  output logic     reqFull,
  output logic     reqEmpty,
  output logic     rspFull,
  output logic     rspEmpty,
  output logic     headIsStore
);
  localparam int MEM_WORDS = 1 << ADDR_W;
  localparam int REQ_BITS  = $bits(req_t);
  localparam int RSP_BITS  = $bits(rsp_t);

  logic [DATA_W-1:0] memWords [MEM_WORDS];
  req_t headReq;
  rsp_t rspIn;

  omp_fifo #(.WIDTH(REQ_BITS), .DEPTH(DEPTH)) reqQ (
    .clk(clk), .rstN(rstN),
    .push(strobes.acceptReq), .pop(strobes.serve),
    .din(reqIn), .dout(headReq),
    .full(reqFull), .empty(reqEmpty)
  );

  assign headIsStore = headReq.isStore;

  always_comb begin
    rspIn.tag   = headReq.tag;
    rspIn.isAck = headReq.isStore;
    rspIn.data  = headReq.isStore ? '0 : memWords[headReq.addr];
  end

  omp_fifo #(.WIDTH(RSP_BITS), .DEPTH(DEPTH)) rspQ (
    .clk(clk), .rstN(rstN),
    .push(strobes.serve), .pop(rspPop),
    .din(rspIn), .dout(rspOut),
    .full(rspFull), .empty(rspEmpty)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_WORDS; i++) memWords[i] <= '0;
    end else if (strobes.writeMem) begin
      memWords[headReq.addr] <= headReq.data;
    end
  end
endmodule

// File: rtl/ordered_mem_port.sv
module ordered_mem_port
  import omp_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [TAG_W-1:0]  reqTag,
  input  logic              reqIsStore,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic              branchOpen,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [TAG_W-1:0]  rspTag,
  output logic              rspIsAck,
  output logic [DATA_W-1:0] rspData
);
  strobes_t strobes;
  req_t     reqIn;
  rsp_t     rspOut;
  logic     reqFull, reqEmpty, rspFull, rspEmpty, headIsStore;

  assign reqIn = '{tag: reqTag, isStore: reqIsStore, addr: reqAddr, data: reqData};

  omp_control u_ctl (
    .reqValid(reqValid), .reqIsStore(reqIsStore), .branchOpen(branchOpen),
    .reqFull(reqFull), .reqEmpty(reqEmpty), .rspFull(rspFull),
    .headIsStore(headIsStore), .reqReady(reqReady), .strobes(strobes)
  );

  omp_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqIn(reqIn),
    .rspPop(rspValid && rspReady), .rspOut(rspOut),
    .reqFull(reqFull), .reqEmpty(reqEmpty), .rspFull(rspFull),
    .rspEmpty(rspEmpty), .headIsStore(headIsStore)
  );

  assign rspValid = !rspEmpty;
  assign rspTag   = rspOut.tag;
  assign rspIsAck = rspOut.isAck;
  assign rspData  = rspOut.data;
endmodule

// File: rtl/omp_checker.sv
module omp_checker #(
  parameter int DEPTH = 4
) (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqReady,
  input logic        reqIsStore,
  input logic        branchOpen,
  input logic        rspValid,
  input logic        rspReady,
  input logic [2:0]  rspTag,
  input logic        rspIsAck,
  input logic [15:0] rspData
);
  int outstanding;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outstanding <= 0;
    else outstanding <= outstanding + int'(reqValid && reqReady)
                                    - int'(rspValid && rspReady);
  end

  // R1: reply output empty right after reset release
  a_r1_reset_empty: assert property (@(posedge clk) $rose(rstN) |-> !rspValid);

  // R4: acknowledgments carry zero data
  a_r4_ack_zero: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspIsAck |-> rspData == '0);

  // R5: store is refused while a branch is open
  a_r5_store_gate: assert property (@(posedge clk) disable iff (!rstN)
    reqIsStore && branchOpen |-> !reqReady);

  // R6: never more than both queues can hold
  a_r6_bounded: assert property (@(posedge clk) disable iff (!rstN)
    outstanding <= 2 * DEPTH);

  // R6: no admission once both queues are full
  a_r6_full_refuse: assert property (@(posedge clk) disable iff (!rstN)
    outstanding == 2 * DEPTH |-> !reqReady);

  // R8: pending reply held stable until taken
  a_r8_rsp_stable: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> rspValid && $stable(rspTag) &&
                              $stable(rspIsAck) && $stable(rspData));

  // R2: a reply exists only for an admitted request
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> outstanding > 0);
endmodule

bind ordered_mem_port omp_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqIsStore(reqIsStore), .branchOpen(branchOpen), .rspValid(rspValid),
  .rspReady(rspReady), .rspTag(rspTag), .rspIsAck(rspIsAck), .rspData(rspData)
);

// File: tb/tb_ordered_mem_port.sv
`timescale 1ns/1ps
module tb_ordered_mem_port;
  logic        clk = 0;
  logic        rstN = 0;
  logic        reqValid = 0, reqIsStore = 0, branchOpen = 0, rspReady = 0;
  logic [2:0]  reqTag = 0;
  logic [7:0]  reqAddr = 0;
  logic [15:0] reqData = 0;
  logic        reqReady, rspValid, rspIsAck;
  logic [2:0]  rspTag;
  logic [15:0] rspData;

  int errors = 0, checks = 0;
  logic [15:0] model [256];
  logic [19:0] expQ [$];   // {tag, isAck, data}

  always #2 clk = ~clk;

  ordered_mem_port dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqTag(reqTag), .reqIsStore(reqIsStore), .reqAddr(reqAddr), .reqData(reqData),
    .branchOpen(branchOpen), .rspValid(rspValid), .rspReady(rspReady),
    .rspTag(rspTag), .rspIsAck(rspIsAck), .rspData(rspData)
  );

  // {isStore, tag, addr, data}
  localparam logic [27:0] VEC [10] = '{
    {1'b0, 3'd0, 8'h10, 16'h0000},
    {1'b1, 3'd1, 8'h10, 16'hBEEF},
    {1'b0, 3'd2, 8'h10, 16'h0000},
    {1'b1, 3'd3, 8'hFF, 16'h1234},
    {1'b1, 3'd4, 8'h00, 16'hA5A5},
    {1'b0, 3'd5, 8'hFF, 16'h0000},
    {1'b0, 3'd6, 8'h00, 16'h0000},
    {1'b1, 3'd7, 8'h10, 16'h0F0F},
    {1'b0, 3'd0, 8'h10, 16'h0000},
    {1'b0, 3'd1, 8'h7E, 16'h0000}
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // offer one request; returns whether it was admitted within waitCycles
  task automatic sendReq(input logic st, input logic [2:0] tg, input logic [7:0] ad,
                         input logic [15:0] dt, input int waitCycles, output logic took);
    took = 0;
    @(negedge clk);
    reqValid = 1; reqIsStore = st; reqTag = tg; reqAddr = ad; reqData = dt;
    for (int c = 0; c < waitCycles && !took; c++) begin
      #0.5;
      if (reqReady) took = 1;
      @(posedge clk);
      @(negedge clk);
    end
    reqValid = 0;
    if (took) begin
      if (st) begin
        model[ad] = dt;
        expQ.push_back({tg, 1'b1, 16'h0000});
      end else begin
        expQ.push_back({tg, 1'b0, model[ad]});
      end
    end
  endtask

  task automatic takeRsp(input string rq);
    logic [19:0] e;
    int w;
    @(negedge clk);
    w = 0;
    while (!rspValid && w < 20) begin @(negedge clk); w++; end
    e = expQ.pop_front();
    chk({rq, " valid"}, 32'(rspValid), 32'd1);
    chk({rq, " reply"}, {12'h0, rspTag, rspIsAck, rspData}, {12'h0, e});
    rspReady = 1;
    @(posedge clk);
    @(negedge clk);
    rspReady = 0;
  endtask

  initial begin
    #150000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic took;
    for (int i = 0; i < 256; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 rspValid after reset", 32'(rspValid), 0);
    chk("R1 reqReady after reset", 32'(reqReady), 1);
    rstN = 1;
    @(negedge clk);
    chk("R1 rspValid idle", 32'(rspValid), 0);

    // table walk: one request, one reply (R1 zero memory, R3, R4)
    foreach (VEC[i]) begin
      sendReq(VEC[i][27], VEC[i][26:24], VEC[i][23:16], VEC[i][15:0], 5, took);
      chk("R3 R4 table admit", 32'(took), 1);
      takeRsp(VEC[i][27] ? "R4 store ack" : "R3 load data");
    end

    // R5: store gated while branch open, load still passes
    branchOpen = 1;
    sendReq(1'b1, 3'd2, 8'h10, 16'hDEAD, 4, took);
    chk("R5 store refused", 32'(took), 0);
    repeat (3) @(negedge clk);
    chk("R5 no reply for refused store", 32'(rspValid), 0);
    sendReq(1'b0, 3'd3, 8'h10, 16'h0000, 4, took);
    chk("R5 load admitted under branch", 32'(took), 1);
    takeRsp("R5 memory unchanged");
    branchOpen = 0;

    // R6 R7 R2: fill both queues with replies blocked
    for (int k = 0; k < 8; k++) begin
      sendReq(k[0], 3'(k), (k < 4) ? 8'h40 : 8'h41, 16'h1000 + 16'(k), 6, took);
      chk("R6 admit while space", 32'(took), 1);
    end
    repeat (4) @(negedge clk);
    sendReq(1'b0, 3'd0, 8'h40, 16'h0, 4, took);
    chk("R6 ninth request refused", 32'(took), 0);
    // R8: held reply stays put
    @(negedge clk);
    chk("R8 reply held", {13'h0, rspTag, rspData}, {13'h0, expQ[0][19:17], expQ[0][15:0]});
    for (int k = 0; k < 8; k++) takeRsp("R2 R7 drain order");
    repeat (3) @(negedge clk);
    chk("R2 queues drained", 32'(rspValid), 0);

    // R1: reset clears memory again
    rstN = 0;
    for (int i = 0; i < 256; i++) model[i] = '0;
    repeat (2) @(negedge clk);
    rstN = 1;
    sendReq(1'b0, 3'd5, 8'h10, 16'h0, 4, took);
    takeRsp("R1 memory zero after reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule